// File: doc/BRIEF.md
# MAC Address Table Command and Scan Controller

This block gives a processor manual access to a MAC address table. Software loads two write-data registers with an entry (MAC address, egress port, static flag, valid flag) and sets the make bit of the command register. The block then places the entry itself: it hashes the low six address bits to a bucket of four ways, overwrites a way that already holds the same address, or takes the lowest free way. A make with the valid flag clear removes the matching entry.

Reading works as an iterator. The get-first command rewinds a scan pointer to slot 0. The get-next command continues from where the last hit left off. Either command steps one slot per clock past invalid slots and copies the next valid entry into two read-data registers. When the pointer runs off the end, the read-data registers read as zero and an end-of-table flag is raised. A status register shows make-pending, read-pending, end-of-table and a bucket-full error. Command bits stay set until software writes them back to zero.

Top module: `addr_table_ctrl`

Register map (word index on `reg_addr`): 0 command, 1 write data low, 2 write data high, 3 read data low, 4 read data high, 5 status.

## Requirements
- R1: Command register bits are bit 2 make, bit 1 get-first and bit 0 get-next. These bits read back as last written, and bits 31:3 always read as zero.
- R2: A command starts only when its bit goes from 0 to 1 in a command write. Writing 0, or writing 1 to a bit that is already set, starts nothing and leaves the status and the table unchanged.
- R3: Make stores the entry at slot bucket*4+way, where bucket = mac[3:0] XOR {2'b00, mac[5:4]} and way is the lowest free way. Make-pending (status bit 0) is high for exactly the one cycle after the command write.
- R4: A make whose MAC matches a valid entry in its bucket overwrites that entry in place (port and static flag updated) and creates no second copy.
- R5: A make with the valid flag clear invalidates the matching entry. If no entry matches, nothing changes and no error is raised.
- R6: A valid make to a bucket whose four ways all hold other addresses writes nothing and sets the full error (status bit 3). The next make clears this error when it starts.
- R7: Get-first rewinds to slot 0 and loads the lowest-index valid entry. Read-pending (status bit 1) stays high for k+1 cycles when the hit is at slot k.
- R8: Get-next continues from one past the last hit and returns valid entries in increasing slot order. It also takes one cycle per slot examined.
- R9: A scan that reaches slot 64 loads zero into both read-data registers and sets end-of-table (status bit 2). The next scan start clears this flag.
- R10: After reset the status, the command and the read-data registers are zero, and the table is empty.
- R11: A command set while another is pending is dropped. When one write sets several bits, make wins over get-first, and get-first wins over get-next.
- R12: The read-data high word holds mac[47:32] in bits 15:0, the port in bits 17:16, the static flag in bit 30 and the valid flag in bit 31. Bits 29:18 are zero. The read-data low word holds mac[31:0]. The write-data registers use the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
A placement fault, such as a wrong hash, a wrong way priority or a missed address match, becomes visible only through a later scan. That scan returns entries in the wrong slot order or returns duplicates. For this reason the bench walks the whole table after every burst of makes. A pointer fault shows up at once as a wrong read-pending length, because each slot costs one cycle. A stale end-of-table or error flag shows up at the next status read after the command that should have cleared it.

// File: rtl/atc_pkg.sv
package atc_pkg;
  parameter int ATC_PORT_W = 2;

  typedef struct packed {
    logic                  vld;
    logic                  stat;
    logic [ATC_PORT_W-1:0] port;
    logic [47:0]           mac;
  } atc_entry_t;

  localparam int HI_PORT_LSB = 16;
  localparam int HI_STAT_BIT = 30;
  localparam int HI_VLD_BIT  = 31;

  typedef enum logic [2:0] {
    RG_CMD   = 3'd0,
    RG_WLO   = 3'd1,
    RG_WHI   = 3'd2,
    RG_RLO   = 3'd3,
    RG_RHI   = 3'd4,
    RG_STAT  = 3'd5
  } atc_reg_e;

  // Fold the six low address bits onto a bucket index of bw bits.
  function automatic logic [5:0] fold_hash(input logic [5:0] low, input int bw);
    logic [5:0] h;
    h = '0;
    for (int i = 0; i < 6; i++) h[i % bw] = h[i % bw] ^ low[i];
    return h;
  endfunction

  function automatic atc_entry_t entry_of(input logic [31:0] lo, input logic [31:0] hi);
    atc_entry_t e;
    e.mac  = {hi[15:0], lo};
    e.port = hi[HI_PORT_LSB +: ATC_PORT_W];
    e.stat = hi[HI_STAT_BIT];
    e.vld  = hi[HI_VLD_BIT];
    return e;
  endfunction

  function automatic logic [31:0] hi_of(input atc_entry_t e);
    logic [31:0] d;
    d = '0;
    d[15:0] = e.mac[47:32];
    d[HI_PORT_LSB +: ATC_PORT_W] = e.port;
    d[HI_STAT_BIT] = e.stat;
    d[HI_VLD_BIT]  = e.vld;
    return d;
  endfunction
endpackage

// File: rtl/atc_regs.sv
module atc_regs
  import atc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        busy,
  input  logic [31:0] rd_lo,
  input  logic [31:0] rd_hi,
  input  logic [31:0] status,
  output logic [31:0] reg_rdata,
  output atc_entry_t  wr_entry,
  output logic        make_start,
  output logic        first_start,
  output logic        next_start
);
  logic [2:0]  cmd_q;
  logic [31:0] wlo_q, whi_q;
  logic [2:0]  rise;
  logic        cmd_wr;

  assign cmd_wr = reg_wr && (reg_addr == RG_CMD);
  assign rise   = cmd_wr ? (reg_wdata[2:0] & ~cmd_q) : 3'b000;

  // Only one command launches per write; busy drops all of them.
  assign make_start  = !busy && rise[2];
  assign first_start = !busy && !rise[2] && rise[1];
  assign next_start  = !busy && !rise[2] && !rise[1] && rise[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      wlo_q <= '0;
      whi_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RG_CMD: cmd_q <= reg_wdata[2:0];
        RG_WLO: wlo_q <= reg_wdata;
        RG_WHI: whi_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign wr_entry = entry_of(wlo_q, whi_q);

  always_comb begin
    case (reg_addr)
      RG_CMD:  reg_rdata = {29'd0, cmd_q};
      RG_WLO:  reg_rdata = wlo_q;
      RG_WHI:  reg_rdata = whi_q;
      RG_RLO:  reg_rdata = rd_lo;
      RG_RHI:  reg_rdata = rd_hi;
      RG_STAT: reg_rdata = status;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/atc_table.sv
module atc_table
  import atc_pkg::*;
#(
  parameter int BUCKET_W = 4,
  parameter int WAYS     = 4,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int IDX_W   = BUCKET_W + WAY_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             make_go,
  input  atc_entry_t       wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output atc_entry_t       rd_entry,
  output logic             full_event
);
  atc_entry_t mem [ENTRIES];

  logic [5:0]          hash;
  logic [BUCKET_W-1:0] bkt;
  logic [WAYS-1:0]     match, free;
  logic [WAY_W-1:0]    match_way, free_way;
  logic                hit_any, free_any;

  assign hash = fold_hash(wr_entry.mac[5:0], BUCKET_W);
  assign bkt  = hash[BUCKET_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    atc_entry_t slot;
    assign slot     = mem[{bkt, WAY_W'(w)}];
    assign match[w] = slot.vld && (slot.mac == wr_entry.mac);
    assign free[w]  = !slot.vld;
  end

  always_comb begin
    match_way = '0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) match_way = WAY_W'(w);
      if (free[w])  free_way  = WAY_W'(w);
    end
  end

  assign hit_any    = |match;
  assign free_any   = |free;
  assign full_event = make_go && wr_entry.vld && !hit_any && !free_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (make_go) begin
      if (hit_any)
        mem[{bkt, match_way}] <= wr_entry;
      else if (wr_entry.vld && free_any)
        mem[{bkt, free_way}] <= wr_entry;
    end
  end

  assign rd_entry = mem[rd_idx];
endmodule

// File: rtl/atc_scan.sv
module atc_scan
  import atc_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_start,
  input  logic             next_start,
  input  atc_entry_t       rd_entry,
  output logic [IDX_W-1:0] rd_idx,
  output logic             scan_busy,
  output logic [31:0]      rd_lo,
  output logic [31:0]      rd_hi,
  output logic             eot,
  output logic             scan_hit,
  output logic             scan_end
);
  logic [PTR_W-1:0] ptr_q;
  logic             at_end;

  assign at_end   = (ptr_q == PTR_W'(ENTRIES));
  assign rd_idx   = ptr_q[IDX_W-1:0];
  assign scan_hit = scan_busy && !at_end && rd_entry.vld;
  assign scan_end = scan_busy && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      scan_busy <= 1'b0;
      rd_lo     <= '0;
      rd_hi     <= '0;
      eot       <= 1'b0;
    end else if (first_start) begin
      ptr_q     <= '0;
      scan_busy <= 1'b1;
      eot       <= 1'b0;
    end else if (next_start) begin
      scan_busy <= 1'b1;
      eot       <= 1'b0;
    end else if (scan_end) begin
      scan_busy <= 1'b0;
      rd_lo     <= '0;
      rd_hi     <= '0;
      eot       <= 1'b1;
    end else if (scan_hit) begin
      scan_busy <= 1'b0;
      rd_lo     <= rd_entry.mac[31:0];
      rd_hi     <= hi_of(rd_entry);
      ptr_q     <= ptr_q + 1'b1;
    end else if (scan_busy) begin
      ptr_q     <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/addr_table_ctrl.sv
module addr_table_ctrl
  import atc_pkg::*;
#(
  parameter int BUCKET_W = 4,
  parameter int WAYS     = 4,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int IDX_W   = BUCKET_W + WAY_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  atc_entry_t       wr_entry, rd_entry;
  logic             make_start, first_start, next_start;
  logic             make_pending, read_pending;
  logic             err_flag, eot_flag, full_event;
  logic             scan_hit, scan_end;
  logic [IDX_W-1:0] rd_idx;
  logic [31:0]      rd_lo, rd_hi, status;

  assign status = {28'd0, err_flag, eot_flag, read_pending, make_pending};

  atc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(make_pending || read_pending),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .status(status), .reg_rdata(reg_rdata),
    .wr_entry(wr_entry), .make_start(make_start),
    .first_start(first_start), .next_start(next_start)
  );

  // Make sequencing: one cycle of pending, table written at its end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      make_pending <= 1'b0;
      err_flag     <= 1'b0;
    end else begin
      make_pending <= make_start;
      if (make_start)      err_flag <= 1'b0;
      else if (full_event) err_flag <= 1'b1;
    end
  end

  atc_table #(.BUCKET_W(BUCKET_W), .WAYS(WAYS)) u_table (
    .clk(clk), .rst_n(rst_n), .make_go(make_pending), .wr_entry(wr_entry),
    .rd_idx(rd_idx), .rd_entry(rd_entry), .full_event(full_event)
  );

  atc_scan #(.ENTRIES(ENTRIES)) u_scan (
    .clk(clk), .rst_n(rst_n), .first_start(first_start),
    .next_start(next_start), .rd_entry(rd_entry), .rd_idx(rd_idx),
    .scan_busy(read_pending), .rd_lo(rd_lo), .rd_hi(rd_hi), .eot(eot_flag),
    .scan_hit(scan_hit), .scan_end(scan_end)
  );
endmodule

// File: rtl/addr_table_ctrl_chk.sv
module addr_table_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        make_start,
  input logic        make_pending,
  input logic        read_pending,
  input logic        scan_hit,
  input logic        scan_end,
  input logic        full_event,
  input logic        err_flag,
  input logic        eot_flag,
  input logic [31:0] rd_lo,
  input logic [31:0] rd_hi
);
  assert_cmd_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> (reg_rdata[31:3] == 29'd0));

  assert_make_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    make_start |=> make_pending);

  assert_make_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    make_pending |=> !make_pending);

  assert_full_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_event |=> err_flag);

  assert_hit_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_hit |=> (!read_pending && rd_hi[31]));

  assert_end_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |=> (eot_flag && !read_pending && rd_lo == 32'd0 && rd_hi == 32'd0));

  assert_single_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(make_pending && read_pending));

  assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    read_pending |-> !make_start);
endmodule

bind addr_table_ctrl addr_table_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .make_start(make_start), .make_pending(make_pending),
  .read_pending(read_pending), .scan_hit(scan_hit), .scan_end(scan_end),
  .full_event(full_event), .err_flag(err_flag), .eot_flag(eot_flag),
  .rd_lo(rd_lo), .rd_hi(rd_hi)
);

// File: tb/addr_table_ctrl_tb.sv
module addr_table_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;

  logic [47:0] m_mac [N];
  logic [1:0]  m_port [N];
  logic        m_stat [N];
  logic        m_vld [N];
  int          m_ptr = 0;

  addr_table_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bkt(input logic [47:0] mac);
    return int'(mac[3:0] ^ {2'b00, mac[5:4]});
  endfunction

  function automatic logic [31:0] hi_word(input logic [47:0] mac, input logic [1:0] port,
                                          input logic st, input logic v);
    return {v, st, 12'd0, port, mac[47:32]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Model of placement; returns the expected error flag.
  task automatic model_make(input logic [47:0] mac, input logic [1:0] port,
                            input logic st, input logic v, output logic err);
    int base, hit, fr;
    base = bkt(mac) * 4; hit = -1; fr = -1; err = 1'b0;
    for (int w = 3; w >= 0; w--) begin
      if (m_vld[base+w] && m_mac[base+w] == mac) hit = base + w;
      if (!m_vld[base+w]) fr = base + w;
    end
    if (hit >= 0) begin
      m_mac[hit] = mac; m_port[hit] = port; m_stat[hit] = st; m_vld[hit] = v;
    end else if (v && fr >= 0) begin
      m_mac[fr] = mac; m_port[fr] = port; m_stat[fr] = st; m_vld[fr] = 1'b1;
    end else if (v) begin
      err = 1'b1;
    end
  endtask

  task automatic do_make(input logic [47:0] mac, input logic [1:0] port,
                         input logic st, input logic v);
    logic [31:0] s, c;
    logic e;
    reg_write(3'd1, mac[31:0]);
    reg_write(3'd2, hi_word(mac, port, st, v));
    reg_write(3'd0, 32'd4);
    reg_read(3'd5, s);
    chk(s[0] == 1'b1, "R3 make pending after write", 64'(s), 64'h1);
    reg_read(3'd0, c);
    chk(c == 32'd4, "R1 command readback", 64'(c), 64'h4);
    model_make(mac, port, st, v, e);
    @(negedge clk);
    reg_read(3'd5, s);
    chk(s[0] == 1'b0, "R3 make pending one cycle", 64'(s[0]), 64'h0);
    chk(s[3] == e, "R6 full error flag", 64'(s[3]), 64'(e));
    reg_write(3'd0, 32'd0);
  endtask

  // Runs a scan command, compares against the model iterator.
  task automatic do_scan(input logic [31:0] cmd);
    logic [31:0] s, lo, hi;
    int cyc, k, start;
    if (cmd[1]) m_ptr = 0;
    start = m_ptr;
    k = m_ptr;
    while (k < N && !m_vld[k]) k++;
    reg_write(3'd0, cmd);
    cyc = 0;
    reg_read(3'd5, s);
    while (s[1] && cyc < 200) begin
      cyc++;
      @(negedge clk);
      reg_read(3'd5, s);
    end
    reg_read(3'd3, lo);
    reg_read(3'd4, hi);
    chk(cyc == k - start + 1, cmd[1] ? "R7 scan length" : "R8 scan length",
        64'(cyc), 64'(k - start + 1));
    if (k < N) begin
      chk(lo == m_mac[k][31:0], "R12 read low word", 64'(lo), 64'(m_mac[k][31:0]));
      chk(hi == hi_word(m_mac[k], m_port[k], m_stat[k], 1'b1), "R12 read high word",
          64'(hi), 64'(hi_word(m_mac[k], m_port[k], m_stat[k], 1'b1)));
      chk(s[2] == 1'b0, "R9 no end flag on hit", 64'(s[2]), 64'h0);
      m_ptr = k + 1;
    end else begin
      chk(lo == 32'd0 && hi == 32'd0, "R9 read data zero at end", {hi, lo}, 64'h0);
      chk(s[2] == 1'b1, "R9 end flag", 64'(s[2]), 64'h1);
      m_ptr = N;
    end
    reg_write(3'd0, 32'd0);
  endtask

  task automatic scan_all();
    do_scan(32'd2);
    while (m_ptr < N) do_scan(32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] s, c;
    logic [47:0] mac;
    void'($urandom(32'd7));
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 1'b0; m_mac[i] = '0; m_port[i] = '0; m_stat[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    reg_read(3'd5, s);
    chk(s == 32'd0, "R10 status after reset", 64'(s), 64'h0);
    reg_read(3'd0, c);
    chk(c == 32'd0, "R10 command after reset", 64'(c), 64'h0);
    reg_read(3'd4, c);
    chk(c == 32'd0, "R10 read data after reset", 64'(c), 64'h0);
    do_scan(32'd2);

    // R11: make set during a long scan on the empty table is dropped
    reg_write(3'd1, 32'h0000_1234);
    reg_write(3'd2, hi_word(48'h0000_0000_1234, 2'd1, 1'b0, 1'b1));
    reg_write(3'd0, 32'd2);
    reg_write(3'd0, 32'd6);
    reg_read(3'd5, s);
    chk(s[0] == 1'b0 && s[1] == 1'b1, "R11 make dropped while scanning", 64'(s[1:0]), 64'h2);
    repeat (70) @(negedge clk);
    reg_write(3'd0, 32'd0);
    scan_all();

    // R1: reserved bits read zero
    reg_write(3'd0, 32'hFFFF_FFF8);
    reg_read(3'd0, c);
    chk(c == 32'd0, "R1 reserved bits zero", 64'(c), 64'h0);
    reg_read(3'd5, s);
    chk(s[1:0] == 2'b00, "R2 zero bits start nothing", 64'(s), 64'h0);

    // R3/R4/R5 directed
    do_make(48'hA1B2_C3D4_E5C5, 2'd2, 1'b1, 1'b1);
    do_make(48'h0102_0304_0500, 2'd1, 1'b0, 1'b1);
    do_make(48'h0102_0304_0511, 2'd3, 1'b0, 1'b1);
    scan_all();
    do_make(48'h0102_0304_0500, 2'd3, 1'b1, 1'b1);   // R4 overwrite
    do_make(48'h0102_0304_0511, 2'd0, 1'b0, 1'b0);   // R5 delete
    do_make(48'h7777_7777_7700, 2'd0, 1'b0, 1'b0);   // R5 absent delete
    scan_all();

    // R6: fill bucket 5, then overflow, then clear
    for (int i = 0; i < 5; i++) do_make({40'(i + 1), 8'h05}, 2'(i), 1'b0, 1'b1);
    do_make(48'h0000_0000_0021, 2'd1, 1'b0, 1'b1);
    do_make({40'd2, 8'h05}, 2'd0, 1'b0, 1'b0);
    do_make({40'd5, 8'h05}, 2'd2, 1'b1, 1'b1);
    scan_all();

    // R2: rewriting a set make bit starts nothing
    reg_write(3'd1, 32'h0000_0009);
    reg_write(3'd2, hi_word(48'h0000_0000_0009, 2'd1, 1'b0, 1'b1));
    reg_write(3'd0, 32'd4);
    @(negedge clk);
    reg_write(3'd0, 32'd4);
    reg_read(3'd5, s);
    chk(s[0] == 1'b0, "R2 set bit rewrite ignored", 64'(s[0]), 64'h0);
    begin logic e; model_make(48'h0000_0000_0009, 2'd1, 1'b0, 1'b1, e); end
    reg_write(3'd0, 32'd0);
    scan_all();

    // R11 priority: first beats next
    do_scan(32'd2);
    do_scan(32'd3);

    // Random phase
    for (int n = 0; n < 120; n++) begin
      logic [5:0] low;
      case ($urandom % 3)
        0: low = 6'h00;
        1: low = 6'h11;
        default: low = 6'h21;
      endcase
      mac = {42'($urandom % 6), low};
      do_make(mac, 2'($urandom), 1'($urandom), ($urandom % 5) != 0);
      if (n % 15 == 14) scan_all();
    end
    scan_all();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule